// File: doc/BRIEF.md
# Temperature-Hinted Re-Reference Replacement Controller

This block keeps the replacement state of one set-associative instruction cache level. For every way of every set it holds a 2-bit re-reference prediction value and a valid flag. From these it names the way that the next fill into the addressed set must replace. The tag and data arrays live elsewhere. This controller only decides where a line goes and how long it is expected to stay.

Each access carries a software-supplied temperature hint, taken from the page attributes. It travels beside the set index and is not stored in the cache arrays. On a fill, the hint chooses the prediction value of the new line: hot lines are inserted as near-term, warm lines one step further out, and cold or unhinted lines as distant. Hot code therefore outlives warm and cold code. A hit promotes the hit way to near-term.

The victim for the set on `lookupSet` appears combinationally on `victimWay`. A `fillStrobe` in the same cycle writes that way and ages the rest of the set when aging is needed.

Top module: `temp_rrip_repl`

## Requirements
- R1: After reset, every way of every set is invalid, and `victimWay` reads 0 for every set index.
- R2: While the addressed set holds an invalid way, `victimWay` is the lowest-numbered invalid way, and a fill marks that way valid.
- R3: When all ways of the set are valid and at least one holds value 3, `victimWay` is the lowest-numbered way holding 3.
- R4: When all ways are valid and none holds 3, the victim is the way found after repeatedly adding 1 to every way until one reaches 3 (the lowest such way). A fill in that case leaves every other way raised by the same total.
- R5: A fill with hint code 2'b11 (hot) writes value 0 into the victim way.
- R6: A fill with hint code 2'b10 (warm) writes value 1 into the victim way.
- R7: A fill with hint code 2'b01 (cold) or 2'b00 (no hint) writes value 3 into the victim way.
- R8: A cycle with `lookupValid` and `lookupHit` both high sets the value of way `hitWay` in the addressed set to 0 and changes no other state. A hit indication while `lookupValid` is low has no effect.
- R9: Every update touches only the set named by `lookupSet`. The state of all other sets is unchanged.
- R10: A `fillStrobe` in a cycle that carries a valid hit is ignored. Only the hit promotion takes place.
- R11: A fill into an invalid way does not age the other ways of the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | An access to `lookupSet` is present this cycle |
| lookupHit | input | 1 | The access hit in the tag array |
| hitWay | input | $clog2(WAYS) | Way that hit |
| fillStrobe | input | 1 | Write the reported victim way of `lookupSet` with a new line |
| tempHint | input | 2 | Temperature of the access: 00 none, 01 cold, 10 warm, 11 hot |
| lookupSet | input | $clog2(SETS) | Set index of the access or fill |
| victimWay | output | $clog2(WAYS) | Way to replace in `lookupSet` |

## Verification
Two events can fall in the same cycle. The first pair is aging and insertion: a fill into a full set in which no way holds 3 must raise every other way while writing the hinted value into the victim. The bench provokes this by filling a set with hot and warm lines and then filling again. The second pair is a hit and a fill strobe in the same cycle, which is driven deliberately and also arises in a pseudo-random sweep over every set. Both cases are judged by comparing later victim choices against a bench model that ages by literal repeated increments.

// File: rtl/temp_rrip_pkg.sv
`timescale 1ns/1ps
package temp_rrip_pkg;

  typedef logic [1:0] rrpv_t;

  typedef enum logic [1:0] {
    HINT_NONE = 2'b00,
    HINT_COLD = 2'b01,
    HINT_WARM = 2'b10,
    HINT_HOT  = 2'b11
  } hint_e;

  localparam rrpv_t RRPV_NEAR    = 2'd0;
  localparam rrpv_t RRPV_MID     = 2'd1;
  localparam rrpv_t RRPV_DISTANT = 2'd3;

  // strobes from control to storage
  typedef struct packed {
    logic  hitWr;    // promote the hit way
    logic  fillWr;   // insert into the chosen way
    rrpv_t ageBy;    // amount added to the other ways on a fill
    rrpv_t insRrpv;  // value written into the filled way
  } upd_t;

endpackage

// File: rtl/temp_rrip_ctrl.sv
`timescale 1ns/1ps
module temp_rrip_ctrl
  import temp_rrip_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        lookupValid,
  input  logic                        lookupHit,
  input  logic [WAY_W-1:0]            hitWay,
  input  logic                        fillStrobe,
  input  logic [1:0]                  tempHint,
  input  logic [WAYS-1:0][1:0]        rowRrpv,
  input  logic [WAYS-1:0]             rowValid,
  output logic [WAY_W-1:0]            victimWay,
  output logic [WAY_W-1:0]            wrWay,
  output upd_t                        upd
);

  logic             anyInvalid;
  logic [WAY_W-1:0] firstInvalid;
  logic [WAY_W-1:0] firstOldest;
  rrpv_t            maxRrpv;

  // victim search: invalid ways first, then oldest prediction
  always_comb begin
    anyInvalid   = 1'b0;
    firstInvalid = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rowValid[w]) begin
        anyInvalid   = 1'b1;
        firstInvalid = WAY_W'(w);
      end
    end
    maxRrpv = RRPV_NEAR;
    for (int w = 0; w < WAYS; w++) begin
      if (rowRrpv[w] > maxRrpv) maxRrpv = rowRrpv[w];
    end
    firstOldest = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (rowRrpv[w] == maxRrpv) firstOldest = WAY_W'(w);
    end
  end

  assign victimWay = anyInvalid ? firstInvalid : firstOldest;

  // strobe decode: a valid hit wins over a fill
  always_comb begin
    upd.hitWr  = lookupValid & lookupHit;
    upd.fillWr = fillStrobe & ~upd.hitWr;
    upd.ageBy  = anyInvalid ? RRPV_NEAR : (RRPV_DISTANT - maxRrpv);
    unique case (hint_e'(tempHint))
      HINT_HOT:  upd.insRrpv = RRPV_NEAR;
      HINT_WARM: upd.insRrpv = RRPV_MID;
      default:   upd.insRrpv = RRPV_DISTANT;
    endcase
  end

  assign wrWay = upd.hitWr ? hitWay : victimWay;

  always_comb begin
    if (anyInvalid) begin
      AST_INVALID_FIRST: assert (!rowValid[victimWay]); // R2
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        AST_VICTIM_IS_OLDEST: assert (rowRrpv[victimWay] >= rowRrpv[w]); // R3
      end
    end
  end

endmodule

// File: rtl/temp_rrip_store.sv
`timescale 1ns/1ps
module temp_rrip_store
  import temp_rrip_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SET_W-1:0]     setIdx,
  input  logic [WAY_W-1:0]     wrWay,
  input  upd_t                 upd,
  output logic [WAYS-1:0][1:0] rowRrpv,
  output logic [WAYS-1:0]      rowValid
);

  logic [WAYS-1:0][1:0] rrpvMem  [SETS];
  logic [WAYS-1:0]      validMem [SETS];

  assign rowRrpv  = rrpvMem[setIdx];
  assign rowValid = validMem[setIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        rrpvMem[s]  <= {WAYS{RRPV_DISTANT}};
        validMem[s] <= '0;
      end
    end else if (upd.hitWr) begin
      rrpvMem[setIdx][wrWay] <= RRPV_NEAR;
    end else if (upd.fillWr) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == wrWay) rrpvMem[setIdx][w] <= upd.insRrpv;
        else                    rrpvMem[setIdx][w] <= rrpvMem[setIdx][w] + upd.ageBy;
      end
      validMem[setIdx][wrWay] <= 1'b1;
    end
  end

  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    upd.hitWr |=> rrpvMem[$past(setIdx)][$past(wrWay)] == RRPV_NEAR); // R8

  AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    upd.fillWr |=> validMem[$past(setIdx)][$past(wrWay)]); // R2

  AST_NO_AGE_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (upd.fillWr && !(&validMem[setIdx])) |-> upd.ageBy == RRPV_NEAR); // R11

  always_comb begin
    if (rstN && upd.fillWr) begin
      for (int w = 0; w < WAYS; w++) begin
        AST_AGE_NO_WRAP: assert ({1'b0, rrpvMem[setIdx][w]} + {1'b0, upd.ageBy} <= 3'd3); // R4
      end
    end
  end

endmodule

// File: rtl/temp_rrip_repl.sv
`timescale 1ns/1ps
module temp_rrip_repl
  import temp_rrip_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupHit,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             fillStrobe,
  input  logic [1:0]       tempHint,
  input  logic [SET_W-1:0] lookupSet,
  output logic [WAY_W-1:0] victimWay
);

  upd_t                 upd;
  logic [WAY_W-1:0]     wrWay;
  logic [WAYS-1:0][1:0] rowRrpv;
  logic [WAYS-1:0]      rowValid;

  temp_rrip_ctrl #(.WAYS(WAYS)) u_ctrl (
    .lookupValid (lookupValid),
    .lookupHit   (lookupHit),
    .hitWay      (hitWay),
    .fillStrobe  (fillStrobe),
    .tempHint    (tempHint),
    .rowRrpv     (rowRrpv),
    .rowValid    (rowValid),
    .victimWay   (victimWay),
    .wrWay       (wrWay),
    .upd         (upd)
  );

  temp_rrip_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .setIdx   (lookupSet),
    .wrWay    (wrWay),
    .upd      (upd),
    .rowRrpv  (rowRrpv),
    .rowValid (rowValid)
  );

endmodule

// File: tb/temp_rrip_repl_bench.sv
`timescale 1ns/1ps
module temp_rrip_repl_bench;

  localparam int WAYS = 4;
  localparam int SETS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lookupValid = 1'b0;
  logic       lookupHit = 1'b0;
  logic [1:0] hitWay = '0;
  logic       fillStrobe = 1'b0;
  logic [1:0] tempHint = '0;
  logic [1:0] lookupSet = '0;
  logic [1:0] victimWay;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int mR [SETS][WAYS];
  int mV [SETS][WAYS];

  always #10 clk = ~clk;

  temp_rrip_repl #(.WAYS(WAYS), .SETS(SETS)) u_temp_rrip_repl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupHit(lookupHit),
    .hitWay(hitWay), .fillStrobe(fillStrobe), .tempHint(tempHint),
    .lookupSet(lookupSet), .victimWay(victimWay)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s victimWay actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic bit allValid(input int s);
    for (int w = 0; w < WAYS; w++) if (mV[s][w] == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit hasThree(input int s);
    for (int w = 0; w < WAYS; w++) if (mR[s][w] == 3) return 1'b1;
    return 1'b0;
  endfunction

  // expected victim: lowest invalid, else age copies one step at a time
  function automatic int modelVictim(input int s);
    int r [WAYS];
    for (int w = 0; w < WAYS; w++) if (mV[s][w] == 0) return w;
    for (int w = 0; w < WAYS; w++) r[w] = mR[s][w];
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < WAYS; w++) if (r[w] == 3) return w;
      for (int w = 0; w < WAYS; w++) r[w] = r[w] + 1;
    end
    return -1;
  endfunction

  function automatic int insValue(input int hint);
    if (hint == 3) return 0;
    if (hint == 2) return 1;
    return 3;
  endfunction

  function automatic string autoTag(input int s);
    if (!allValid(s)) return "R2";
    if (hasThree(s)) return "R3";
    return "R4";
  endfunction

  task automatic step(input string tag, input int s, input bit lv, input bit lh,
                      input int hw, input bit fs, input int hint);
    int exp;
    @(negedge clk);
    lookupSet = 2'(s); lookupValid = lv; lookupHit = lh; hitWay = 2'(hw);
    fillStrobe = fs; tempHint = 2'(hint);
    #2;
    exp = modelVictim(s);
    chk(tag, int'(victimWay), exp);
    if (lv && lh) begin
      mR[s][hw] = 0;
    end else if (fs) begin
      if (allValid(s)) begin
        while (!hasThree(s)) for (int w = 0; w < WAYS; w++) mR[s][w] = mR[s][w] + 1;
      end
      mR[s][exp] = insValue(hint);
      mV[s][exp] = 1;
    end
    @(posedge clk);
    #1;
    lookupValid = 1'b0; lookupHit = 1'b0; fillStrobe = 1'b0;
  endtask

  task automatic peek(input string tag, input int s, input int exp);
    @(negedge clk);
    lookupSet = 2'(s); lookupValid = 1'b0; fillStrobe = 1'b0;
    #2;
    chk(tag, int'(victimWay), exp);
  endtask

  initial begin
    int seed;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mR[s][w] = 3; mV[s][w] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state in every set
    for (int s = 0; s < SETS; s++) peek("R1", s, 0);

    // R2 fills into invalid ways, R11 no aging of others
    step("R2", 0, 0, 0, 0, 1, 3);
    step("R11", 0, 0, 0, 0, 1, 2);
    step("R2", 0, 0, 0, 0, 1, 0);
    step("R2", 0, 0, 0, 0, 1, 1);
    // set0 now 0,1,3,3: R7 none/cold both distant -> way 2
    peek("R7", 0, 2);

    // set1: hot, hot, warm, hot -> 0,0,1,0
    step("R2", 1, 0, 0, 0, 1, 3);
    step("R2", 1, 0, 0, 0, 1, 3);
    step("R2", 1, 0, 0, 0, 1, 2);
    step("R2", 1, 0, 0, 0, 1, 3);
    peek("R6", 1, 2);
    // aging and hot insertion in the same cycle: others 0->2, way2 <- 0
    step("R4", 1, 0, 0, 0, 1, 3);
    peek("R5", 1, 0);
    // hit promotes way0
    step("R8", 1, 1, 1, 0, 0, 0);
    peek("R8", 1, 1);
    // hit without lookupValid is ignored
    step("R8", 1, 0, 1, 1, 0, 0);
    peek("R8", 1, 1);
    // hit plus fill in one cycle: fill ignored
    step("R10", 1, 1, 1, 1, 1, 1);
    peek("R10", 1, 3);
    // other set untouched
    peek("R9", 0, 2);
    peek("R9", 2, 0);

    // pseudo-random sweep over every set
    seed = 32'h1ACE_5EED;
    for (int i = 0; i < 4000; i++) begin
      int s, kind;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      s = seed & 3;
      kind = (seed >>> 4) & 7;
      step(autoTag(s), s, kind[0] | kind[1], kind[1], (seed >>> 8) & 3,
           kind[2] | kind[0], (seed >>> 12) & 3);
      if (i % 500 == 0) peek("R9", (s + 1) & 3, modelVictim((s + 1) & 3));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule